// File: doc/BRIEF.md
# Serial EEPROM Word Reader

This block reads a run of 16-bit words from a three-wire serial EEPROM. The
host sets a first word address, a word count, a byte-swap flag and a settle
value, then pulses `start`. For each word the block first drives a forced
idle sequence. It then opens an access, clocks out an 11-bit read command,
clocks in 16 data bits and runs a second idle sequence. The word is then
offered on a valid/ready output.

Every line change on the serial side is spaced by a settle time of system
clocks, so the serial clock rate follows from `settle_cycles` and the system
clock. Addresses go up by one per word and wrap within the address width.
With the swap flag set, the two bytes of each word are exchanged before the
word is offered. Writes, erases and status polling are not part of this
block.

Top module: `eewr_word_reader`

## Requirements
- R1: After reset `busy`, `word_valid`, `ee_sel`, `ee_cs`, `ee_sk` and `ee_di` are all 0.
- R2: A `start` pulse with a non-zero `word_count` while idle raises `busy` until the last word is accepted. A `start` with `word_count` equal to 0, or any `start` while busy, is ignored.
- R3: Before and after each word read, the block runs an idle session. `ee_cs` is high for exactly 26 rising edges of `ee_sk` (the clock raise plus 25 pulses), then `ee_cs` falls. Every read session sits between two idle sessions.
- R4: In a read session `ee_cs` is high for exactly 27 rising edges of `ee_sk`. The `ee_di` values at the first 11 rising edges form, MSB first, the value 11'h180 OR the 6-bit word address. That places a start bit 1 at bit 8, the read code 2'b10 at bits 7:6 and the address at bits 5:0.
- R5: The 16 data bits are taken MSB first from `ee_do` while `ee_sk` is high, one after each of rising edges 12 to 27 of the read session.
- R6: A run of N words reads addresses start, start+1, … modulo 64 and presents exactly N words in that order.
- R7: With `swap_bytes` set at start, each presented word has bits 15:8 and 7:0 exchanged.
- R8: While `word_valid` is high and `word_ready` is low, `word_valid` stays high and `word_data` stays unchanged.
- R9: Two changes of `ee_sk` are at least S+1 system clocks apart, where S is `settle_cycles` (a value of 0 counts as 1).
- R10: `ee_sk` is high only while `ee_cs` is high, and `ee_cs` is high only while `ee_sel` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a read run |
| start_addr | input | 6 | First word address |
| word_count | input | 8 | Number of words to read |
| swap_bytes | input | 1 | Exchange the bytes of every word |
| settle_cycles | input | 8 | System clocks per serial step, minus one |
| busy | output | 1 | Run in progress |
| word_valid | output | 1 | `word_data` holds a word |
| word_ready | input | 1 | Consumer takes the word |
| word_data | output | 16 | Word read from the EEPROM |
| ee_sel | output | 1 | Serial interface enabled (select and read mode) |
| ee_cs | output | 1 | EEPROM chip select |
| ee_sk | output | 1 | EEPROM serial clock |
| ee_di | output | 1 | Serial data towards the EEPROM |
| ee_do | input | 1 | Serial data from the EEPROM |

## Verification
A serial EEPROM model answers each read command with an address-dependent
pattern, so a wrong address, an off-by-one bit shift or a bit-order error
each shows up as a different mismatch. The runs cover several cases:
- a single word;
- several words under steady and stalled `word_ready`, which separates ordering errors from handshake errors;
- a run that wraps past address 63;
- a swapped run, which separates the byte-exchange path from the shift path;
- a settle value of 0, which exercises the minimum step length.

A `start` with a zero count and a second `start` during a run test that
commands are ignored when they should be.

// File: rtl/eewr_pkg.sv
package eewr_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRE,
    ST_ACC,
    ST_CMD,
    ST_DAT,
    ST_POST,
    ST_OUT
  } rd_state_t;

  typedef struct packed {
    logic sel;
    logic cs;
    logic sk;
    logic di;
  } ee_lines_t;

endpackage

// File: rtl/eewr_settle_timer.sv
module eewr_settle_timer #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             run,
  input  logic [DIV_W-1:0] settle,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] reload;

  assign reload = (settle == '0) ? DIV_W'(1) : settle;
  assign tick   = run && !load && (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= reload;
    end else if (run) begin
      cnt <= (cnt == '0) ? reload : cnt - 1'b1;
    end
  end
endmodule

// File: rtl/eewr_line_decode.sv
module eewr_line_decode import eewr_pkg::*; #(
  parameter int IDLE_PULSES = 25,
  parameter int PH_W        = 6,
  parameter int BC_W        = 4,
  parameter int CMD_W       = 11
) (
  input  rd_state_t        st,
  input  logic [PH_W-1:0]  ph,
  input  logic [BC_W-1:0]  bc,
  input  logic [CMD_W-1:0] cmd,
  output ee_lines_t        lines
);
  localparam int PULSE_END = 3 + 2 * IDLE_PULSES;

  logic [PH_W-1:0]  pulse_idx;
  logic [CMD_W-1:0] cmd_shifted;

  assign pulse_idx   = ph - PH_W'(3);
  assign cmd_shifted = cmd << bc;

  always_comb begin
    lines = '0;
    unique case (st)
      ST_PRE, ST_POST: begin
        if (int'(ph) <= PULSE_END + 1) lines.sel = 1'b1;
        if (int'(ph) >= 1 && int'(ph) <= PULSE_END) lines.cs = 1'b1;
        if (int'(ph) == 2) lines.sk = 1'b1;
        else if (int'(ph) >= 3 && int'(ph) < PULSE_END) lines.sk = pulse_idx[0];
      end
      ST_ACC: begin
        lines.sel = 1'b1;
        lines.cs  = (ph != '0);
        lines.sk  = (int'(ph) == 2);
      end
      ST_CMD: begin
        lines.sel = 1'b1;
        lines.cs  = 1'b1;
        lines.di  = cmd_shifted[CMD_W-1];
        lines.sk  = (int'(ph) == 1) || (ph == '0 && bc == '0);
      end
      ST_DAT: begin
        lines.sel = 1'b1;
        lines.cs  = 1'b1;
        lines.sk  = (int'(ph) != 2);
      end
      default: lines = '0;
    endcase
  end
endmodule

// File: rtl/eewr_rx_shift.sv
module eewr_rx_shift #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              shift_en,
  input  logic              bit_in,
  input  logic              swap,
  output logic [DATA_W-1:0] word
);
  localparam int HALF = DATA_W / 2;

  logic [DATA_W-1:0] sreg;

  always_ff @(posedge clk) begin
    if (rst) sreg <= '0;
    else if (shift_en) sreg <= {sreg[DATA_W-2:0], bit_in};
  end

  assign word = swap ? {sreg[HALF-1:0], sreg[DATA_W-1:HALF]} : sreg;
endmodule

// File: rtl/eewr_word_reader.sv
module eewr_word_reader import eewr_pkg::*; #(
  parameter int         ADDR_W      = 6,
  parameter int         CNT_W       = 8,
  parameter int         DIV_W       = 8,
  parameter int         DATA_W      = 16,
  parameter int         CMD_W       = 11,
  parameter int         IDLE_PULSES = 25,
  parameter logic [2:0] READ_CODE   = 3'b110
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [CNT_W-1:0]  word_count,
  input  logic              swap_bytes,
  input  logic [DIV_W-1:0]  settle_cycles,
  output logic              busy,
  output logic              word_valid,
  input  logic              word_ready,
  output logic [DATA_W-1:0] word_data,
  output logic              ee_sel,
  output logic              ee_cs,
  output logic              ee_sk,
  output logic              ee_di,
  input  logic              ee_do
);
  localparam int IDLE_STEPS = 2 * IDLE_PULSES + 6;
  localparam int PH_W       = $clog2(IDLE_STEPS);
  localparam int BITS_MAX   = (DATA_W > CMD_W) ? DATA_W : CMD_W;
  localparam int BC_W       = $clog2(BITS_MAX);
  localparam logic [PH_W-1:0] PH_IDLE_LAST = PH_W'(IDLE_STEPS - 1);
  localparam logic [PH_W-1:0] PH_STEP_LAST = PH_W'(2);
  localparam logic [BC_W-1:0] BC_CMD_LAST  = BC_W'(CMD_W - 1);
  localparam logic [BC_W-1:0] BC_DAT_LAST  = BC_W'(DATA_W - 1);

  rd_state_t         st;
  logic [PH_W-1:0]   ph;
  logic [BC_W-1:0]   bc;
  logic [ADDR_W-1:0] addr_q;
  logic [CNT_W-1:0]  left_q;
  logic              swap_q;
  logic [DIV_W-1:0]  settle_q;
  logic              restart_q;
  logic              timed, tick, sample;
  logic [CMD_W-1:0]  cmd_word;
  logic [DATA_W-1:0] rx_word;
  ee_lines_t         nxt_lines, lines_q;

  assign timed    = (st == ST_PRE) || (st == ST_ACC) || (st == ST_CMD) ||
                    (st == ST_DAT) || (st == ST_POST);
  assign sample   = tick && (st == ST_DAT) && (ph == '0);
  assign cmd_word = CMD_W'({READ_CODE, addr_q});

  eewr_settle_timer #(.DIV_W(DIV_W)) u_timer (
    .clk(clk), .rst(rst), .load(restart_q), .run(timed),
    .settle(settle_q), .tick(tick)
  );

  eewr_line_decode #(
    .IDLE_PULSES(IDLE_PULSES), .PH_W(PH_W), .BC_W(BC_W), .CMD_W(CMD_W)
  ) u_decode (
    .st(st), .ph(ph), .bc(bc), .cmd(cmd_word), .lines(nxt_lines)
  );

  eewr_rx_shift #(.DATA_W(DATA_W)) u_rx (
    .clk(clk), .rst(rst), .shift_en(sample), .bit_in(ee_do),
    .swap(swap_q), .word(rx_word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_IDLE;
      ph         <= '0;
      bc         <= '0;
      addr_q     <= '0;
      left_q     <= '0;
      swap_q     <= 1'b0;
      settle_q   <= '0;
      restart_q  <= 1'b0;
      busy       <= 1'b0;
      word_valid <= 1'b0;
      word_data  <= '0;
      lines_q    <= '0;
    end else begin
      restart_q <= 1'b0;
      lines_q   <= nxt_lines;
      unique case (st)
        ST_IDLE: if (start && word_count != '0) begin
          addr_q    <= start_addr;
          left_q    <= word_count;
          swap_q    <= swap_bytes;
          settle_q  <= settle_cycles;
          busy      <= 1'b1;
          ph        <= '0;
          bc        <= '0;
          restart_q <= 1'b1;
          st        <= ST_PRE;
        end
        ST_PRE, ST_POST: if (tick) begin
          if (ph == PH_IDLE_LAST) begin
            ph <= '0;
            if (st == ST_PRE) begin
              st <= ST_ACC;
            end else begin
              word_data  <= rx_word;
              word_valid <= 1'b1;
              st         <= ST_OUT;
            end
          end else begin
            ph <= ph + 1'b1;
          end
        end
        ST_ACC: if (tick) begin
          if (ph == PH_STEP_LAST) begin
            ph <= '0;
            bc <= '0;
            st <= ST_CMD;
          end else begin
            ph <= ph + 1'b1;
          end
        end
        ST_CMD, ST_DAT: if (tick) begin
          if (ph == PH_STEP_LAST) begin
            ph <= '0;
            if (st == ST_CMD && bc == BC_CMD_LAST) begin
              bc <= '0;
              st <= ST_DAT;
            end else if (st == ST_DAT && bc == BC_DAT_LAST) begin
              bc <= '0;
              st <= ST_POST;
            end else begin
              bc <= bc + 1'b1;
            end
          end else begin
            ph <= ph + 1'b1;
          end
        end
        ST_OUT: if (word_ready) begin
          word_valid <= 1'b0;
          if (left_q == CNT_W'(1)) begin
            busy <= 1'b0;
            st   <= ST_IDLE;
          end else begin
            left_q    <= left_q - 1'b1;
            addr_q    <= addr_q + 1'b1;
            ph        <= '0;
            restart_q <= 1'b1;
            st        <= ST_PRE;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign ee_sel = lines_q.sel;
  assign ee_cs  = lines_q.cs;
  assign ee_sk  = lines_q.sk;
  assign ee_di  = lines_q.di;
endmodule

// File: rtl/eewr_word_reader_chk.sv
module eewr_word_reader_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              busy,
  input logic              word_valid,
  input logic              word_ready,
  input logic [DATA_W-1:0] word_data,
  input logic              ee_sel,
  input logic              ee_cs,
  input logic              ee_sk
);
  // R8
  hold_word_chk: assert property (@(posedge clk) disable iff (rst)
    word_valid && !word_ready |=> word_valid && $stable(word_data));

  // R10
  sk_needs_cs_chk: assert property (@(posedge clk) disable iff (rst)
    ee_sk |-> ee_cs);

  // R10
  cs_needs_sel_chk: assert property (@(posedge clk) disable iff (rst)
    ee_cs |-> ee_sel);

  // R2
  valid_in_run_chk: assert property (@(posedge clk) disable iff (rst)
    word_valid |-> busy);

  // R2
  quiet_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !ee_sel && !ee_cs && !ee_sk);

  // R9
  sk_spacing_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ee_sk) || $fell(ee_sk) |=> $stable(ee_sk));
endmodule

bind eewr_word_reader eewr_word_reader_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .busy(busy), .word_valid(word_valid),
  .word_ready(word_ready), .word_data(word_data), .ee_sel(ee_sel),
  .ee_cs(ee_cs), .ee_sk(ee_sk)
);

// File: tb/test_eewr_word_reader.sv
`timescale 1ns/1ps
module test_eewr_word_reader;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [5:0]  start_addr = '0;
  logic [7:0]  word_count = '0;
  logic        swap_bytes = 1'b0;
  logic [7:0]  settle_cycles = 8'd2;
  logic        busy, word_valid, word_ready;
  logic [15:0] word_data;
  logic        ee_sel, ee_cs, ee_sk, ee_di;
  logic        ee_do = 1'b0;

  always #5 clk = ~clk;

  eewr_word_reader i_eewr_word_reader (
    .clk(clk), .rst(rst), .start(start), .start_addr(start_addr),
    .word_count(word_count), .swap_bytes(swap_bytes),
    .settle_cycles(settle_cycles), .busy(busy), .word_valid(word_valid),
    .word_ready(word_ready), .word_data(word_data), .ee_sel(ee_sel),
    .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_di(ee_di), .ee_do(ee_do)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int words_total = 0;
  int idle_sessions = 0;
  int cur_s = 2;
  int ready_mode = 0;
  bit done = 0;

  logic [15:0] exp_q[$];
  logic [5:0]  addr_q[$];

  function automatic logic [15:0] rom_word(input logic [5:0] a);
    logic [15:0] t;
    t = {10'd0, a} * 16'h9E37;
    return t ^ 16'h5A1C;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // EEPROM model
  int          rises = 0;
  logic [10:0] cmd_sh = '0;
  logic [15:0] cur_word = '0;
  bit          last_idle = 0;

  always @(posedge ee_cs) begin
    rises = 0;
    cmd_sh = '0;
  end

  always @(posedge ee_sk) begin
    if (ee_cs) begin
      rises++;
      if (rises <= 11) cmd_sh = {cmd_sh[9:0], ee_di};
      if (rises == 11) cur_word = rom_word(cmd_sh[5:0]);
      if (rises >= 12 && rises <= 27) ee_do = cur_word[27 - rises];
    end
  end

  always @(negedge ee_cs) begin
    logic [5:0] ea;
    if (rises == 26) begin
      idle_sessions++;
      check(1'b1, "R3", "idle session", rises, 26);
      last_idle = 1;
    end else if (rises == 27) begin
      check(last_idle, "R3", "read session not preceded by idle", 0, 1);
      last_idle = 0;
      if (addr_q.size() == 0) begin
        check(1'b0, "R6", "unexpected read command", int'(cmd_sh), 0);
      end else begin
        ea = addr_q.pop_front();
        check(cmd_sh == (11'h180 | {5'd0, ea}), "R4", "command field",
              int'(cmd_sh), int'(11'h180 | {5'd0, ea}));
      end
    end else begin
      check(1'b0, "R3", "session clock edge count", rises, 26);
    end
  end

  // R9 spacing of serial clock changes
  int   gap = 1000;
  logic sk_prev = 1'b0;
  always @(negedge clk) begin
    gap++;
    if (ee_sk !== sk_prev) begin
      check(gap >= cur_s + 1, "R9", "serial clock spacing", gap, cur_s + 1);
      gap = 0;
    end
    sk_prev = ee_sk;
  end

  // ready driver and monitor (scoreboard)
  logic [15:0] held_data = '0;
  bit          held = 0;
  always @(negedge clk) begin
    logic [15:0] e;
    cyc++;
    if (ready_mode == 0) word_ready = 1'b1;
    else word_ready = (cyc % 3) == 0;
    if (rst) word_ready = 1'b0;
    if (held) begin
      check(word_valid && word_data == held_data, "R8", "word held while stalled",
            int'(word_data), int'(held_data));
    end
    held = 0;
    if (word_valid && !rst) begin
      check(busy, "R2", "busy during run", int'(busy), 1);
      if (word_ready) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R6", "extra word", int'(word_data), 0);
        end else begin
          e = exp_q.pop_front();
          check(word_data == e, "R5 R6 R7", "word value", int'(word_data), int'(e));
        end
      end else begin
        held = 1;
        held_data = word_data;
      end
    end
  end

  task automatic push_run(input logic [5:0] a, input int n, input bit sw);
    for (int i = 0; i < n; i++) begin
      logic [5:0]  aa;
      logic [15:0] w;
      aa = a + 6'(i);
      w = rom_word(aa);
      if (sw) w = {w[7:0], w[15:8]};
      exp_q.push_back(w);
      addr_q.push_back(aa);
    end
    words_total += n;
  endtask

  task automatic pulse_start(input logic [5:0] a, input int n, input bit sw,
                             input int s);
    start_addr = a;
    word_count = 8'(n);
    swap_bytes = sw;
    settle_cycles = 8'(s);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done();
    while (exp_q.size() != 0) @(negedge clk);
    @(negedge clk);
    check(!busy, "R2", "busy clears after last word", int'(busy), 0);
  endtask

  task automatic run_read(input logic [5:0] a, input int n, input bit sw,
                          input int s);
    @(negedge clk);
    cur_s = (s == 0) ? 1 : s;
    push_run(a, n, sw);
    pulse_start(a, n, sw, s);
    wait_done();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  always @(negedge clk) begin
    if (cyc > 150000) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 150000);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(!busy, "R1", "busy after reset", int'(busy), 0);
    check(!word_valid, "R1", "valid after reset", int'(word_valid), 0);
    check({ee_sel, ee_cs, ee_sk, ee_di} == 4'b0, "R1", "lines after reset",
          int'({ee_sel, ee_cs, ee_sk, ee_di}), 0);

    // R2 zero count is ignored
    pulse_start(6'd5, 0, 1'b0, 2);
    repeat (20) @(negedge clk);
    check(!busy && !ee_sel, "R2", "zero count start ignored", int'(busy), 0);

    // single word, then a stalled multi-word run
    run_read(6'd0, 1, 1'b0, 2);
    ready_mode = 1;
    run_read(6'd17, 3, 1'b0, 3);
    ready_mode = 0;

    // R6 wrap past the top address
    run_read(6'd62, 4, 1'b0, 1);

    // R7 byte swap
    run_read(6'd33, 2, 1'b1, 2);

    // R9 settle of zero counts as one
    run_read(6'd9, 2, 1'b0, 0);

    // R2 start during a run is ignored
    @(negedge clk);
    cur_s = 2;
    push_run(6'd10, 3, 1'b0);
    pulse_start(6'd10, 3, 1'b0, 2);
    repeat (60) @(negedge clk);
    check(busy, "R2", "busy during run", int'(busy), 1);
    pulse_start(6'd40, 5, 1'b1, 1);
    wait_done();

    repeat (10) @(negedge clk);
    check(exp_q.size() == 0 && addr_q.size() == 0, "R6", "all words seen",
          exp_q.size() + addr_q.size(), 0);
    check(idle_sessions == 2 * words_total, "R3", "idle sessions per word",
          idle_sessions, 2 * words_total);
    finish_run();
  end
endmodule